// File: doc/BRIEF.md
# Data Address Translation Cache

This block holds recently used leaf translations for data accesses. A requester presents an effective page number and a load/store flag. In the same cycle the block answers with a hit, the real page number, the seven permission and attribute bits, and a permission-fault flag. When no translation is found, the block raises a request for a table walk. It holds that request until the walker supplies a translation on the fill port. The block then writes that translation into its array.

Storage has 64 sets of two ways each. The set is chosen by the low six bits of the effective page number, and the remaining bits form the tag. Pages 4 KB in size are assumed, so an effective address contributes bits above bit 11. Each set keeps one replacement bit. A shootdown port accepts one operand. The fixed code 0xC00 empties the whole array in one cycle. Any other value is taken as a page-aligned address, and only that page is dropped.

A small two-state controller tracks the outstanding walk. In state IDLE, no walk is in flight. Transition IDLE to WALK happens on a genuine lookup miss, and the missed page number is captured. In state WALK, `walk_req` is high. Transition WALK to IDLE happens on any fill. While in WALK, further misses do not start a second walk.

Top module: `dtlb`

## Requirements
- R1: After reset every entry is invalid, `walk_req` is low and every lookup misses with `lk_rpn`, `lk_perm` and `lk_fault` at zero.
- R2: A lookup of a resident page returns `lk_hit`=1 with that page's real page number and permission bits in the same cycle, without waiting for a clock edge. The permission bit positions are: bit0 execute, bit1 write, bit2 read, bit3 privileged, bit4 non-cacheable, bit5 referenced, bit6 changed. On a miss all three data outputs are zero.
- R3: The set index is `lk_epn[5:0]` and the tag is the upper page-number bits. Two pages with the same index, such as effective addresses 0x124000 and 0x1124000, stay resident together. A page that shares only the index with them misses.
- R4: In IDLE, a lookup miss that is not a collision makes `walk_req` rise on the next edge, with `walk_epn` equal to the missed page number. Both hold steady until a fill arrives, and `walk_req` falls on the edge after the fill. A miss during WALK does not change `walk_epn`.
- R5: A fill is visible to a lookup on the following cycle. A fill writes a way that already holds the same page if there is one. Otherwise it writes the first invalid way, with way 0 before way 1. Otherwise it writes the way named by the set's replacement bit.
- R6: Each hit and each fill mark the used way as most recent, so the next full-set fill evicts the other way.
- R7: A lookup in the same cycle as a fill to the same set returns a miss and starts no walk. The same lookup retried later hits.
- R8: An invalidate with operand 0xC00 clears all entries on one edge.
- R9: An invalidate with any other operand clears only the entry for page `inv_op[31:12]`. Other pages stay resident.
- R10: When an invalidate and a fill occur in the same cycle, the fill is discarded.
- R11: On a hit, a load faults unless read and referenced are both set. A store faults unless write, referenced and changed are all set. `lk_fault` is never high on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup strobe |
| lk_epn | input | 20 | Effective page number to translate |
| lk_store | input | 1 | 1 = store access, 0 = load |
| lk_hit | output | 1 | Translation found this cycle |
| lk_rpn | output | 20 | Real page number on hit, else 0 |
| lk_perm | output | 7 | Permission/attribute bits on hit, else 0 |
| lk_fault | output | 1 | Hit whose bits forbid this access |
| walk_req | output | 1 | Table walk outstanding |
| walk_epn | output | 20 | Page number the walk is for |
| fill_valid | input | 1 | Walker result strobe |
| fill_epn | input | 20 | Page number being installed |
| fill_rpn | input | 20 | Real page number being installed |
| fill_perm | input | 7 | Permission bits being installed |
| inv_valid | input | 1 | Invalidate strobe |
| inv_op | input | 32 | 0xC00 = all entries, else page-aligned address |

## Verification
The assertions check several things on every cycle:
- Outputs are quiet on a miss, and the fault flag agrees with the returned bits.
- A lookup that collides with a fill is forced to miss.
- The walk request starts, holds and ends as R4 describes.
- A fill is visible on the next cycle.
- Either invalidate form removes the targeted translation by the next cycle.

Only the bench scenarios can show which way a fill evicts, because that depends on the history of replacement bits. The same holds for two same-set pages staying resident together, for an invalidate winning over a simultaneous fill, and for the reset state.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;

    localparam int TLB_WAYS = 2;
    localparam int PERM_W   = 7;

    // bit positions inside the permission vector
    localparam int PB_EXEC = 0;
    localparam int PB_WR   = 1;
    localparam int PB_RD   = 2;
    localparam int PB_PRIV = 3;
    localparam int PB_NC   = 4;
    localparam int PB_REFD = 5;
    localparam int PB_CHG  = 6;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } walk_st_e;

endpackage

// File: rtl/dtlb_match.sv
module dtlb_match #(
    parameter int TAG_W = 14,
    parameter int WAYS  = 2,
    localparam int WAY_BITS = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [WAYS-1:0]            way_vld,
    input  logic [TAG_W-1:0]           probe_tag,
    output logic [WAYS-1:0]            hit_vec,
    output logic                       hit_any,
    output logic [WAY_BITS-1:0]        hit_way
);
    for (genvar g = 0; g < WAYS; g++) begin : g_way
        assign hit_vec[g] = way_vld[g] && (way_tag[g] == probe_tag);
    end

    assign hit_any = |hit_vec;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_BITS'(w);
        end
    end
endmodule

// File: rtl/dtlb_victim.sv
module dtlb_victim (
    input  logic [1:0] way_vld,
    input  logic       lru_way,
    input  logic       same_page,
    input  logic       same_way,
    output logic       victim
);
    always_comb begin
        if (same_page)       victim = same_way;
        else if (!way_vld[0]) victim = 1'b0;
        else if (!way_vld[1]) victim = 1'b1;
        else                  victim = lru_way;
    end
endmodule

// File: rtl/dtlb.sv
module dtlb
    import dtlb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int SET_BITS  = 6,
    parameter int RPN_W     = 20,
    parameter logic [ADDR_W-1:0] INV_ALL_CODE = 'hC00
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        lk_valid,
    input  logic [ADDR_W-PAGE_BITS-1:0] lk_epn,
    input  logic                        lk_store,
    output logic                        lk_hit,
    output logic [RPN_W-1:0]            lk_rpn,
    output logic [PERM_W-1:0]           lk_perm,
    output logic                        lk_fault,
    output logic                        walk_req,
    output logic [ADDR_W-PAGE_BITS-1:0] walk_epn,
    input  logic                        fill_valid,
    input  logic [ADDR_W-PAGE_BITS-1:0] fill_epn,
    input  logic [RPN_W-1:0]            fill_rpn,
    input  logic [PERM_W-1:0]           fill_perm,
    input  logic                        inv_valid,
    input  logic [ADDR_W-1:0]           inv_op
);
    localparam int EPN_W = ADDR_W - PAGE_BITS;
    localparam int TAG_W = EPN_W - SET_BITS;
    localparam int SETS  = 1 << SET_BITS;
    localparam int WAYS  = TLB_WAYS;

    // storage
    logic [WAYS-1:0][TAG_W-1:0]  tag_q  [SETS];
    logic [WAYS-1:0][RPN_W-1:0]  rpn_q  [SETS];
    logic [WAYS-1:0][PERM_W-1:0] perm_q [SETS];
    logic [WAYS-1:0]             vld_q  [SETS];
    logic [SETS-1:0]             lru_q;      // way to replace next

    // address split
    logic [SET_BITS-1:0] lk_set, fl_set, iv_set;
    logic [TAG_W-1:0]    lk_tag, fl_tag, iv_tag;
    assign lk_set = lk_epn[SET_BITS-1:0];
    assign lk_tag = lk_epn[EPN_W-1:SET_BITS];
    assign fl_set = fill_epn[SET_BITS-1:0];
    assign fl_tag = fill_epn[EPN_W-1:SET_BITS];
    assign iv_set = inv_op[PAGE_BITS +: SET_BITS];
    assign iv_tag = inv_op[ADDR_W-1:PAGE_BITS+SET_BITS];

    // lookup compare
    logic [WAYS-1:0] lk_vec;
    logic            lk_any, lk_way;
    dtlb_match #(.TAG_W(TAG_W), .WAYS(WAYS)) u_lk_match (
        .way_tag(tag_q[lk_set]), .way_vld(vld_q[lk_set]), .probe_tag(lk_tag),
        .hit_vec(lk_vec), .hit_any(lk_any), .hit_way(lk_way)
    );

    // fill compare (duplicate page detection)
    logic [WAYS-1:0] fl_vec;
    logic            fl_any, fl_way, victim;
    dtlb_match #(.TAG_W(TAG_W), .WAYS(WAYS)) u_fl_match (
        .way_tag(tag_q[fl_set]), .way_vld(vld_q[fl_set]), .probe_tag(fl_tag),
        .hit_vec(fl_vec), .hit_any(fl_any), .hit_way(fl_way)
    );

    dtlb_victim u_victim (
        .way_vld(vld_q[fl_set]), .lru_way(lru_q[fl_set]),
        .same_page(fl_any), .same_way(fl_way), .victim(victim)
    );

    // invalidate compare
    logic [WAYS-1:0] iv_vec;
    logic            iv_any, iv_way;
    dtlb_match #(.TAG_W(TAG_W), .WAYS(WAYS)) u_iv_match (
        .way_tag(tag_q[iv_set]), .way_vld(vld_q[iv_set]), .probe_tag(iv_tag),
        .hit_vec(iv_vec), .hit_any(iv_any), .hit_way(iv_way)
    );

    logic inv_all, inv_page, collide, real_miss, fill_wr;
    assign inv_all   = inv_valid && (inv_op == INV_ALL_CODE);
    assign inv_page  = inv_valid && !inv_all;
    assign collide   = fill_valid && (fl_set == lk_set);
    assign real_miss = lk_valid && !lk_any && !collide;
    assign fill_wr   = fill_valid && !inv_valid;

    // lookup outputs
    logic ld_bad, st_bad;
    assign lk_hit  = lk_valid && lk_any && !collide;
    assign lk_rpn  = lk_hit ? rpn_q[lk_set][lk_way]  : '0;
    assign lk_perm = lk_hit ? perm_q[lk_set][lk_way] : '0;
    assign ld_bad  = !(lk_perm[PB_RD] && lk_perm[PB_REFD]);
    assign st_bad  = !(lk_perm[PB_WR] && lk_perm[PB_REFD] && lk_perm[PB_CHG]);
    assign lk_fault = lk_hit && (lk_store ? st_bad : ld_bad);

    // valid and replacement state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
            lru_q <= '0;
        end else if (inv_all) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
        end else begin
            if (inv_page && iv_any) begin
                vld_q[iv_set][iv_way] <= 1'b0;
            end else if (fill_wr) begin
                vld_q[fl_set][victim] <= 1'b1;
                lru_q[fl_set]         <= ~victim;
            end
            if (lk_hit) lru_q[lk_set] <= ~lk_way;
        end
    end

    // entry payload (no reset needed: guarded by valid)
    always_ff @(posedge clk) begin
        if (fill_wr) begin
            tag_q[fl_set][victim]  <= fl_tag;
            rpn_q[fl_set][victim]  <= fill_rpn;
            perm_q[fl_set][victim] <= fill_perm;
        end
    end

    // walk controller
    walk_st_e state_q, state_d;
    logic [EPN_W-1:0] walk_epn_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (real_miss)  state_d = ST_WALK;
            ST_WALK: if (fill_valid) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            walk_epn_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && real_miss) walk_epn_q <= lk_epn;
        end
    end

    always_comb begin
        walk_req = (state_q == ST_WALK);
        walk_epn = walk_epn_q;
    end
endmodule

// File: rtl/dtlb_checker.sv
module dtlb_checker #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int SET_BITS  = 6,
    parameter int RPN_W     = 20,
    parameter logic [ADDR_W-1:0] INV_ALL_CODE = 'hC00
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        lk_valid,
    input logic [ADDR_W-PAGE_BITS-1:0] lk_epn,
    input logic                        lk_store,
    input logic                        lk_hit,
    input logic [RPN_W-1:0]            lk_rpn,
    input logic [6:0]                  lk_perm,
    input logic                        lk_fault,
    input logic                        walk_req,
    input logic [ADDR_W-PAGE_BITS-1:0] walk_epn,
    input logic                        fill_valid,
    input logic [ADDR_W-PAGE_BITS-1:0] fill_epn,
    input logic [RPN_W-1:0]            fill_rpn,
    input logic [6:0]                  fill_perm,
    input logic                        inv_valid,
    input logic [ADDR_W-1:0]           inv_op
);
    logic same_set, inv_all;
    assign same_set = fill_valid && (fill_epn[SET_BITS-1:0] == lk_epn[SET_BITS-1:0]);
    assign inv_all  = inv_valid && (inv_op == INV_ALL_CODE);

    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_rpn == '0 && lk_perm == '0 && !lk_fault)); // R2
    AST_LOAD_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && !lk_store && lk_perm[2] && lk_perm[5]) |-> !lk_fault); // R11
    AST_STORE_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_store && lk_perm[1] && lk_perm[5] && lk_perm[6]) |-> !lk_fault); // R11
    AST_COLLIDE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && same_set) |-> !lk_hit); // R7
    AST_WALK_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!walk_req && lk_valid && !lk_hit && !same_set) |=> (walk_req && walk_epn == $past(lk_epn))); // R4
    AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !fill_valid) |=> (walk_req && $stable(walk_epn))); // R4
    AST_WALK_END: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && fill_valid) |=> !walk_req); // R4
    AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !inv_valid) |=>
        (!(lk_valid && !fill_valid && lk_epn == $past(fill_epn)) ||
         (lk_hit && lk_rpn == $past(fill_rpn) && lk_perm == $past(fill_perm)))); // R5
    AST_GLOBAL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> !lk_hit); // R8
    AST_PAGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !inv_all) |=>
        (!(lk_valid && lk_epn == $past(inv_op[ADDR_W-1:PAGE_BITS])) || !lk_hit)); // R9
endmodule

bind dtlb dtlb_checker #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .SET_BITS(SET_BITS),
    .RPN_W(RPN_W), .INV_ALL_CODE(INV_ALL_CODE)
) u_dtlb_checker (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_epn(lk_epn),
    .lk_store(lk_store), .lk_hit(lk_hit), .lk_rpn(lk_rpn), .lk_perm(lk_perm),
    .lk_fault(lk_fault), .walk_req(walk_req), .walk_epn(walk_epn),
    .fill_valid(fill_valid), .fill_epn(fill_epn), .fill_rpn(fill_rpn),
    .fill_perm(fill_perm), .inv_valid(inv_valid), .inv_op(inv_op)
);

// File: tb/dtlb_bench.sv
module dtlb_bench;
    localparam int CLK_PERIOD = 10;

    localparam logic [1:0] OPL = 2'd0, OPF = 2'd1, OPI = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] addr;
        logic        st;
        logic [19:0] rpn;
        logic [6:0]  perm;
        logic        hit;
        logic        flt;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t TBL [NV] = '{
        '{OPL, 32'h00124000, 1'b0, 20'h0,  7'h00, 1'b0, 1'b0, 4'd1},  // cold miss
        '{OPF, 32'h00124000, 1'b0, 20'h4,  7'h66, 1'b0, 1'b0, 4'd0},
        '{OPL, 32'h00124108, 1'b0, 20'h4,  7'h66, 1'b1, 1'b0, 4'd2},
        '{OPF, 32'h01124000, 1'b0, 20'h9,  7'h66, 1'b0, 1'b0, 4'd0},  // same set
        '{OPL, 32'h01124000, 1'b1, 20'h9,  7'h66, 1'b1, 1'b0, 4'd3},
        '{OPL, 32'h00124000, 1'b0, 20'h4,  7'h66, 1'b1, 1'b0, 4'd3},
        '{OPL, 32'h02124000, 1'b0, 20'h0,  7'h00, 1'b0, 1'b0, 4'd3},  // index alias only
        '{OPF, 32'h00149000, 1'b0, 20'h5,  7'h06, 1'b0, 1'b0, 4'd0},
        '{OPL, 32'h00149000, 1'b0, 20'h5,  7'h06, 1'b1, 1'b1, 4'd11}, // no referenced
        '{OPF, 32'h0010a000, 1'b0, 20'h6,  7'h26, 1'b0, 1'b0, 4'd0},
        '{OPL, 32'h0010a000, 1'b0, 20'h6,  7'h26, 1'b1, 1'b0, 4'd11},
        '{OPL, 32'h0010a000, 1'b1, 20'h6,  7'h26, 1'b1, 1'b1, 4'd11}, // no changed
        '{OPF, 32'h0020b000, 1'b0, 20'h7,  7'h24, 1'b0, 1'b0, 4'd0},
        '{OPL, 32'h0020b000, 1'b1, 20'h7,  7'h24, 1'b1, 1'b1, 4'd11}, // no write
        '{OPL, 32'h0020b000, 1'b0, 20'h7,  7'h24, 1'b1, 1'b0, 4'd11},
        '{OPF, 32'h0030c000, 1'b0, 20'h8,  7'h20, 1'b0, 1'b0, 4'd0},
        '{OPL, 32'h0030c000, 1'b0, 20'h8,  7'h20, 1'b1, 1'b1, 4'd11}, // no read
        '{OPI, 32'h00149000, 1'b0, 20'h0,  7'h00, 1'b0, 1'b0, 4'd0},
        '{OPL, 32'h00149000, 1'b0, 20'h0,  7'h00, 1'b0, 1'b0, 4'd9},
        '{OPL, 32'h0010a000, 1'b0, 20'h6,  7'h26, 1'b1, 1'b0, 4'd9},
        '{OPL, 32'h00124000, 1'b0, 20'h4,  7'h66, 1'b1, 1'b0, 4'd9}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid, lk_store, fill_valid, inv_valid;
    logic [19:0] lk_epn, fill_epn, fill_rpn;
    logic [6:0]  fill_perm;
    logic [31:0] inv_op;
    logic        lk_hit, lk_fault, walk_req;
    logic [19:0] lk_rpn, walk_epn;
    logic [6:0]  lk_perm;

    logic        cap_hit, cap_fault;
    logic [19:0] cap_rpn;
    logic [6:0]  cap_perm;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dtlb u_dtlb (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_epn(lk_epn),
        .lk_store(lk_store), .lk_hit(lk_hit), .lk_rpn(lk_rpn), .lk_perm(lk_perm),
        .lk_fault(lk_fault), .walk_req(walk_req), .walk_epn(walk_epn),
        .fill_valid(fill_valid), .fill_epn(fill_epn), .fill_rpn(fill_rpn),
        .fill_perm(fill_perm), .inv_valid(inv_valid), .inv_op(inv_op)
    );

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd1:  return "R1";
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd9:  return "R9";
            4'd11: return "R11";
            default: return "R?";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic quiet();
        lk_valid = 0; lk_epn = '0; lk_store = 0;
        fill_valid = 0; fill_epn = '0; fill_rpn = '0; fill_perm = '0;
        inv_valid = 0; inv_op = '0;
    endtask

    task automatic do_reset();
        rst_n = 0; quiet();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
    endtask

    task automatic step(input logic lv, input logic [19:0] le, input logic ls,
                        input logic fv, input logic [19:0] fe, input logic [19:0] fr,
                        input logic [6:0] fp, input logic iv, input logic [31:0] io);
        @(negedge clk);
        lk_valid = lv; lk_epn = le; lk_store = ls;
        fill_valid = fv; fill_epn = fe; fill_rpn = fr; fill_perm = fp;
        inv_valid = iv; inv_op = io;
        #1;
        cap_hit = lk_hit; cap_rpn = lk_rpn; cap_perm = lk_perm; cap_fault = lk_fault;
        @(posedge clk); #1;
        quiet();
    endtask

    task automatic look(input logic [19:0] e, input logic st);
        step(1, e, st, 0, '0, '0, '0, 0, '0);
    endtask

    task automatic fill(input logic [19:0] e, input logic [19:0] r, input logic [6:0] p);
        step(0, '0, 0, 1, e, r, p, 0, '0);
    endtask

    initial begin
        vec_t v;
        quiet();
        do_reset();

        // table-driven sweep
        for (int i = 0; i < NV; i++) begin
            v = TBL[i];
            case (v.op)
                OPL: begin
                    look(v.addr[31:12], v.st);
                    chk(req_name(v.req), "hit",   32'(cap_hit),   32'(v.hit));
                    chk(req_name(v.req), "rpn",   32'(cap_rpn),   32'(v.hit ? v.rpn : 20'h0));
                    chk(req_name(v.req), "perm",  32'(cap_perm),  32'(v.hit ? v.perm : 7'h0));
                    chk(req_name(v.req), "fault", 32'(cap_fault), 32'(v.flt));
                end
                OPF: fill(v.addr[31:12], v.rpn, v.perm);
                default: step(0, '0, 0, 0, '0, '0, '0, 1, v.addr);
            endcase
        end

        // R1: reset state
        do_reset();
        chk("R1", "walk_req after reset", 32'(walk_req), 32'h0);
        look(20'h00124, 0);
        chk("R1", "hit after reset", 32'(cap_hit), 32'h0);
        chk("R1", "rpn after reset", 32'(cap_rpn), 32'h0);

        // R4: walk request life cycle
        do_reset();
        look(20'h00777, 0);
        chk("R4", "walk_req after miss", 32'(walk_req), 32'h1);
        chk("R4", "walk_epn", 32'(walk_epn), 32'h00777);
        look(20'h00888, 0);
        chk("R4", "walk_req held", 32'(walk_req), 32'h1);
        chk("R4", "walk_epn held", 32'(walk_epn), 32'h00777);
        fill(20'h00777, 20'h00abc, 7'h66);
        chk("R4", "walk_req after fill", 32'(walk_req), 32'h0);

        // R5 / R6: way choice and replacement in set 0x15
        fill(20'h00015, 20'h0000a, 7'h66);   // A -> way0
        fill(20'h00055, 20'h0000b, 7'h66);   // B -> way1
        look(20'h00015, 0);                  // A becomes most recent
        chk("R5", "A hit before eviction", 32'(cap_hit), 32'h1);
        fill(20'h00095, 20'h0000c, 7'h66);   // C must evict B
        look(20'h00015, 0);
        chk("R6", "A kept", 32'(cap_rpn), 32'h0000a);
        look(20'h00095, 0);
        chk("R6", "C installed", 32'(cap_rpn), 32'h0000c);
        look(20'h00055, 0);
        chk("R6", "B evicted", 32'(cap_hit), 32'h0);
        fill(20'h00015, 20'h0001a, 7'h66);   // refill A in place
        look(20'h00015, 0);
        chk("R5", "A overwritten", 32'(cap_rpn), 32'h0001a);
        look(20'h00095, 0);
        chk("R5", "C survives refill", 32'(cap_hit), 32'h1);

        // R7: collision with a fill to the same set
        chk("R7", "idle before collision", 32'(walk_req), 32'h0);
        step(1, 20'h00095, 0, 1, 20'h000d5, 20'h0000d, 7'h66, 0, '0);
        chk("R7", "collision hit", 32'(cap_hit), 32'h0);
        chk("R7", "no walk on collision", 32'(walk_req), 32'h0);
        look(20'h00095, 0);
        chk("R7", "retry hits", 32'(cap_rpn), 32'h0000c);

        // R10: invalidate beats simultaneous fill
        step(0, '0, 0, 1, 20'h00600, 20'h00066, 7'h66, 1, 32'h00500000);
        look(20'h00600, 0);
        chk("R10", "dropped fill", 32'(cap_hit), 32'h0);

        // R8: global invalidate
        fill(20'h00095, 20'h0000c, 7'h66);
        look(20'h00095, 0);
        chk("R8", "resident before", 32'(cap_hit), 32'h1);
        step(0, '0, 0, 0, '0, '0, '0, 1, 32'h00000c00);
        look(20'h00095, 0);
        chk("R8", "C cleared", 32'(cap_hit), 32'h0);
        look(20'h000d5, 0);
        chk("R8", "D cleared", 32'(cap_hit), 32'h0);
        look(20'h00777, 0);
        chk("R8", "other set cleared", 32'(cap_hit), 32'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule